// File: doc/BRIEF.md
# Energy-Detect Power-Down Controller

This block manages an automatic low-power mode for the datapath of an Ethernet PHY. It watches a digital energy-present flag from the line receiver. When the mode is enabled and the line has been quiet for a programmable number of cycles, it turns the transmit and receive datapath off. It also holds transmit inhibited and blocks receive-valid. The management side, the squelch logic and the energy detector stay powered throughout. Only the datapath is gated.

When line energy returns (link pulses or frames), the datapath powers up at once. Transmit and receive stay blocked for a fixed ready delay, so the first frame or two that caused the wake may be dropped. The block then returns to normal operation with the configuration it held before sleeping. The wake sets a sticky flag at bit 1 of an interrupt status word. Masking that flag produces the interrupt request to the host. The host clears the flag with a write-one-to-clear.

The receive stream is a valid-only sideband with no back-pressure. A beat is passed on only while the block is fully active. Beats offered at any other time are dropped, not stalled, because the line receiver cannot be held off.

Top module: `edpd_ctrl`

## Requirements
- R1: After reset, `dp_power_en` is 1, `tx_inhibit` is 0, `int_status` is 0 and `irq_req` is 0.
- R2: While `mode_en` is 0, a low `energy_in` never powers the datapath down.
- R3: With `mode_en` at 1, `energy_in` passes through a two-flop synchronizer and the synchronized value must be low for `debounce_len` consecutive clock edges (0 is treated as 1). The datapath then powers down, with `dp_power_en` at 0 and `tx_inhibit` at 1. A low `energy_in` held for `debounce_len`+2 edges gives this state; a shorter low pulse has no effect.
- R4: When `energy_in` rises while powered down, `dp_power_en` returns to 1 on the third clock edge. `tx_inhibit` stays 1 for a further READY_CYC edges and then drops to 0.
- R5: `rx_valid_out` equals `rx_valid_in` only while fully active (`tx_inhibit` 0); otherwise it is 0.
- R6: Each energy wake sets `int_status` bit 1, which stays set until cleared. All other status bits read 0.
- R7: A cycle with `status_wr` at 1 clears `int_status` bit 1 if `status_wdata` bit 1 is 1. Written zeros and other bits have no effect. A wake event in the same cycle wins over the clear.
- R8: `irq_req` is 1 exactly when some bit is set in both `int_status` and `int_mask`.
- R9: Clearing `mode_en` while powered down returns the block to fully active on the next edge, without setting the status flag.
- R10: `cfg_out` follows `cfg_in` (one register delay) while active. It holds the last active value while powered down and during the ready delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_en | input | 1 | Power-down mode enable |
| energy_in | input | 1 | Asynchronous energy-present flag |
| debounce_len | input | DEB_W | Quiet cycles required before sleep |
| int_mask | input | STAT_W | Interrupt enable mask |
| status_wr | input | 1 | Status write strobe |
| status_wdata | input | STAT_W | Write-one-to-clear data |
| cfg_in | input | CFG_W | Live operating configuration |
| rx_valid_in | input | 1 | Receive beat valid from line side |
| dp_power_en | output | 1 | Datapath power enable |
| tx_inhibit | output | 1 | Transmit blocked |
| rx_valid_out | output | 1 | Gated receive valid |
| cfg_out | output | CFG_W | Configuration applied to the datapath |
| int_status | output | STAT_W | Sticky interrupt status |
| irq_req | output | 1 | Interrupt request |

## Verification
A wrong sequencer state shows at the ports within one edge. `dp_power_en` and `tx_inhibit` decode the state directly, so a stuck sleep or a skipped ready delay appears on the next sample. An off-by-one in the debounce or ready counter moves the power edges by one cycle. The bench samples each edge at the exact cycle count for this reason. A flag that is lost or set wrongly shows on `int_status` and `irq_req` at the edge after the event.

// File: rtl/edpd_pkg.sv
package edpd_pkg;
  typedef enum logic [1:0] {
    PS_ACTIVE = 2'd0,
    PS_SLEEP  = 2'd1,
    PS_WAKE   = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/edpd_sync.sv
module edpd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q[g] <= 1'b1;
        else if (g == 0) chain_q[g] <= d_async;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/edpd_seq.sv
module edpd_seq
  import edpd_pkg::*;
#(
  parameter int DEB_W     = 8,
  parameter int READY_CYC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_en,
  input  logic             energy_s,
  input  logic [DEB_W-1:0] debounce_len,
  output pwr_state_e       state,
  output logic             wake_evt
);
  localparam int RDY_W = (READY_CYC < 2) ? 1 : $clog2(READY_CYC);
  localparam logic [RDY_W-1:0] RDY_LAST = RDY_W'(READY_CYC - 1);

  pwr_state_e       state_q, state_d;
  logic [DEB_W-1:0] quiet_q, quiet_d;
  logic [RDY_W-1:0] rdy_q, rdy_d;
  logic [DEB_W-1:0] quiet_last;

  assign quiet_last = (debounce_len == '0) ? '0 : debounce_len - 1'b1;

  always_comb begin
    state_d  = state_q;
    quiet_d  = '0;
    rdy_d    = '0;
    wake_evt = 1'b0;
    unique case (state_q)
      PS_ACTIVE: begin
        if (mode_en && !energy_s) begin
          if (quiet_q >= quiet_last) state_d = PS_SLEEP;
          else quiet_d = quiet_q + 1'b1;
        end
      end
      PS_SLEEP: begin
        if (!mode_en) begin
          state_d = PS_ACTIVE;
        end else if (energy_s) begin
          state_d  = PS_WAKE;
          wake_evt = 1'b1;
        end
      end
      PS_WAKE: begin
        if (rdy_q >= RDY_LAST) state_d = PS_ACTIVE;
        else rdy_d = rdy_q + 1'b1;
      end
      default: state_d = PS_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= PS_ACTIVE;
      quiet_q <= '0;
      rdy_q   <= '0;
    end else begin
      state_q <= state_d;
      quiet_q <= quiet_d;
      rdy_q   <= rdy_d;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/edpd_status.sv
module edpd_status #(
  parameter int STAT_W   = 8,
  parameter int WAKE_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_evt,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] status
);
  genvar b;
  generate
    for (b = 0; b < STAT_W; b++) begin : g_bit
      if (b == WAKE_BIT) begin : g_live
        logic flag_q;
        always_ff @(posedge clk) begin
          if (!rst_n) flag_q <= 1'b0;
          else if (set_evt) flag_q <= 1'b1;
          else if (wr_en && wr_data[b]) flag_q <= 1'b0;
        end
        assign status[b] = flag_q;
      end else begin : g_rsvd
        assign status[b] = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/edpd_ctrl.sv
module edpd_ctrl
  import edpd_pkg::*;
#(
  parameter int DEB_W       = 8,
  parameter int READY_CYC   = 8,
  parameter int STAT_W      = 8,
  parameter int WAKE_BIT    = 1,
  parameter int CFG_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_en,
  input  logic              energy_in,
  input  logic [DEB_W-1:0]  debounce_len,
  input  logic [STAT_W-1:0] int_mask,
  input  logic              status_wr,
  input  logic [STAT_W-1:0] status_wdata,
  input  logic [CFG_W-1:0]  cfg_in,
  input  logic              rx_valid_in,
  output logic              dp_power_en,
  output logic              tx_inhibit,
  output logic              rx_valid_out,
  output logic [CFG_W-1:0]  cfg_out,
  output logic [STAT_W-1:0] int_status,
  output logic              irq_req
);
  logic       energy_s;
  logic       wake_evt;
  pwr_state_e state;
  logic [CFG_W-1:0] hold_q;

  edpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(energy_in), .d_sync(energy_s)
  );

  edpd_seq #(.DEB_W(DEB_W), .READY_CYC(READY_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .energy_s(energy_s),
    .debounce_len(debounce_len), .state(state), .wake_evt(wake_evt)
  );

  edpd_status #(.STAT_W(STAT_W), .WAKE_BIT(WAKE_BIT)) u_status (
    .clk(clk), .rst_n(rst_n), .set_evt(wake_evt), .wr_en(status_wr),
    .wr_data(status_wdata), .status(int_status)
  );

  // Configuration shadow: frozen while the datapath is not fully active.
  always_ff @(posedge clk) begin
    if (!rst_n) hold_q <= '0;
    else if (state == PS_ACTIVE) hold_q <= cfg_in;
  end

  assign cfg_out      = hold_q;
  assign dp_power_en  = (state != PS_SLEEP);
  assign tx_inhibit   = (state != PS_ACTIVE);
  assign rx_valid_out = rx_valid_in && (state == PS_ACTIVE);
  assign irq_req      = |(int_status & int_mask);
endmodule

// File: rtl/edpd_ctrl_sva.sv
module edpd_ctrl_sva #(
  parameter int STAT_W   = 8,
  parameter int WAKE_BIT = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_en,
  input logic              status_wr,
  input logic [STAT_W-1:0] status_wdata,
  input logic [STAT_W-1:0] int_mask,
  input logic              dp_power_en,
  input logic              tx_inhibit,
  input logic              rx_valid_out,
  input logic [STAT_W-1:0] int_status,
  input logic              irq_req
);
  AST_SLEEP_INHIBITS: assert property (@(posedge clk) disable iff (!rst_n)
    !dp_power_en |-> tx_inhibit); // R3
  AST_DISABLED_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mode_en) |-> dp_power_en); // R2
  AST_ENERGY_WAKE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dp_power_en) && $past(mode_en) |-> tx_inhibit); // R4
  AST_RX_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_inhibit |-> !rx_valid_out); // R5
  AST_WAKE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dp_power_en) && tx_inhibit |-> int_status[WAKE_BIT]); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(int_status[WAKE_BIT]) && !$past(status_wr && status_wdata[WAKE_BIT])
    |-> int_status[WAKE_BIT]); // R7
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (int_mask == '0) |-> !irq_req); // R8
  AST_FORCED_WAKE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dp_power_en) && !$past(mode_en) && !$past(int_status[WAKE_BIT])
    |-> !int_status[WAKE_BIT]); // R9
endmodule

bind edpd_ctrl edpd_ctrl_sva #(.STAT_W(STAT_W), .WAKE_BIT(WAKE_BIT)) u_sva (
  .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .status_wr(status_wr),
  .status_wdata(status_wdata), .int_mask(int_mask), .dp_power_en(dp_power_en),
  .tx_inhibit(tx_inhibit), .rx_valid_out(rx_valid_out),
  .int_status(int_status), .irq_req(irq_req)
);

// File: tb/edpd_ctrl_test.sv
module edpd_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_en, energy_in, status_wr, rx_valid_in;
  logic [7:0] debounce_len, int_mask, status_wdata;
  logic [3:0] cfg_in, cfg_out;
  logic       dp_power_en, tx_inhibit, rx_valid_out, irq_req;
  logic [7:0] int_status;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  edpd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .energy_in(energy_in),
    .debounce_len(debounce_len), .int_mask(int_mask), .status_wr(status_wr),
    .status_wdata(status_wdata), .cfg_in(cfg_in), .rx_valid_in(rx_valid_in),
    .dp_power_en(dp_power_en), .tx_inhibit(tx_inhibit),
    .rx_valid_out(rx_valid_out), .cfg_out(cfg_out),
    .int_status(int_status), .irq_req(irq_req)
  );

  typedef struct packed {
    logic       mode;
    logic       energy;
    logic [7:0] waitc;
    logic       pwr;
    logic       inh;
  } vec_t;

  // debounce_len = 4, READY_CYC = 8: sleep after 6 edges low, power back
  // 3 edges after rise, active 11 edges after rise.
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 8'd20, 1'b1, 1'b0},  // R2 disabled, quiet line
    '{1'b1, 1'b1, 8'd3,  1'b1, 1'b0},
    '{1'b1, 1'b0, 8'd3,  1'b1, 1'b0},  // R3 short quiet start
    '{1'b1, 1'b1, 8'd10, 1'b1, 1'b0},  // R3 glitch ignored
    '{1'b1, 1'b0, 8'd5,  1'b1, 1'b0},  // R3 one edge early
    '{1'b1, 1'b0, 8'd1,  1'b0, 1'b1},  // R3 asleep
    '{1'b1, 1'b1, 8'd2,  1'b0, 1'b1},  // R4 still asleep
    '{1'b1, 1'b1, 8'd1,  1'b1, 1'b1},  // R4 powered, inhibited
    '{1'b1, 1'b1, 8'd7,  1'b1, 1'b1},  // R4 ready delay
    '{1'b1, 1'b1, 8'd1,  1'b1, 1'b0}   // R4 active
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  initial begin
    tick(20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; mode_en = 0; energy_in = 1; status_wr = 0; rx_valid_in = 0;
    debounce_len = 8'd4; int_mask = 8'h02; status_wdata = 0; cfg_in = 0;
    tick(3);
    chk("R1 power", {7'd0, dp_power_en}, 8'd1);
    chk("R1 inhibit", {7'd0, tx_inhibit}, 8'd0);
    chk("R1 status", int_status, 8'd0);
    chk("R1 irq", {7'd0, irq_req}, 8'd0);
    rst_n = 1;
    tick(2);

    for (int i = 0; i < NV; i++) begin
      mode_en = VECS[i].mode;
      energy_in = VECS[i].energy;
      tick(int'(VECS[i].waitc));
      chk($sformatf("R2/R3/R4 vector %0d power", i), {7'd0, dp_power_en}, {7'd0, VECS[i].pwr});
      chk($sformatf("R2/R3/R4 vector %0d inhibit", i), {7'd0, tx_inhibit}, {7'd0, VECS[i].inh});
    end

    chk("R6 wake flag", int_status, 8'h02);
    chk("R8 irq enabled", {7'd0, irq_req}, 8'd1);
    int_mask = 8'h00; tick(1);
    chk("R8 irq masked", {7'd0, irq_req}, 8'd0);
    int_mask = 8'h02;

    status_wr = 1; status_wdata = 8'h01; tick(1); status_wr = 0;
    chk("R7 other bit write ignored", int_status, 8'h02);
    status_wr = 1; status_wdata = 8'h02; tick(1); status_wr = 0;
    chk("R7 cleared", int_status, 8'h00);
    chk("R8 irq after clear", {7'd0, irq_req}, 8'd0);

    cfg_in = 4'hA; rx_valid_in = 1; tick(1);
    chk("R5 rx passes active", {7'd0, rx_valid_out}, 8'd1);
    chk("R10 cfg follows", {4'd0, cfg_out}, 8'h0A);
    energy_in = 0; tick(6);
    chk("R3 asleep again", {7'd0, dp_power_en}, 8'd0);
    cfg_in = 4'h5; tick(1);
    chk("R10 cfg held asleep", {4'd0, cfg_out}, 8'h0A);
    chk("R5 rx blocked asleep", {7'd0, rx_valid_out}, 8'd0);
    energy_in = 1; tick(3);
    chk("R5 rx blocked waking", {7'd0, rx_valid_out}, 8'd0);
    chk("R10 cfg held waking", {4'd0, cfg_out}, 8'h0A);
    chk("R6 flag set again", int_status, 8'h02);
    tick(8);
    chk("R5 rx passes after ready", {7'd0, rx_valid_out}, 8'd1);
    chk("R10 cfg restored", {4'd0, cfg_out}, 8'h0A);
    tick(1);
    chk("R10 cfg updates", {4'd0, cfg_out}, 8'h05);
    status_wr = 1; status_wdata = 8'h02; tick(1); status_wr = 0;

    energy_in = 0; tick(6);
    chk("R9 asleep", {7'd0, dp_power_en}, 8'd0);
    mode_en = 0; tick(1);
    chk("R9 forced power", {7'd0, dp_power_en}, 8'd1);
    chk("R9 forced active", {7'd0, tx_inhibit}, 8'd0);
    chk("R9 no flag", int_status, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule